// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a single-port synchronous SRAM. Reads are flow-through, and no idle cycle is needed between writes and reads. Each rising edge at which the active-low clock enable is low captures one command. The command either loads a new external address and access type, or advances a two-bit burst counter through the four-word group that holds the loaded address. The counter steps in either linear or interleaved order.

A write command takes its data from the write bus one enabled edge later. Each 9-bit lane (8 data bits plus a parity bit) is guarded by its own active-low strobe. The write bus is therefore free for a read in the very next cycle. Read data appears after the edge that captured the read and holds until the next enabled edge. The output-drive flag is forced low during write beats, while deselected, during sleep and after reset. The asynchronous output enable gates it at any time.

The data bus is split into a write word, a read word and a drive flag, so that the model can be used inside a chip without tristate nets. The clock enable acts as the stall control for the whole pipeline. Memory depth is set by the address-width parameter.

Top module: `sync_burst_sram`

## Requirements
- R1: At a rising edge with `clk_en_n` high, no input is captured and no state changes: a held read keeps `rdata`/`rdata_oe`, and a pending write is not committed.
- R2: The device counts as selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at a load edge (`advance`=0). Any other combination at such an edge deselects it, and `rdata_oe` is 0 after that edge.
- R3: At a selected load edge, `addr` becomes the burst base and the first beat accesses `addr` itself; `wr_n`=0 makes it a write, `wr_n`=1 a read.
- R4: Each enabled edge with `advance`=1 during an active burst steps a 2-bit count n (mod 4). The beat address keeps the base's upper bits, with low two bits (base+n) mod 4 when `order_ilv`=0, or base XOR n when `order_ilv`=1. A fifth beat returns to the base.
- R5: The access type loaded at the start of a burst applies to every advance beat; `wr_n` is ignored on advance edges.
- R6: A write beat takes its data from `wdata` at the next enabled edge. Lane i is `wdata[9i+8:9i]` and is written only if `lane_wr_n[i]` was 0 at the beat's command edge. With all strobes high, nothing is written.
- R7: After an enabled edge captures a read beat, `rdata` shows the stored word until the next enabled edge. This includes a word written by the data of that same edge, so a read can directly follow a write to the same address.
- R8: `rdata_oe` is 0 after reset, after a write beat is captured, and after a deselect. It stays 0 through stalls until an enabled edge captures a read.
- R9: `out_en_n`=1 forces `rdata_oe` to 0 without waiting for a clock edge; returning it to 0 restores the drive for a held read.
- R10: A deselect ends any burst. An advance edge with no active burst performs no access and leaves `rdata_oe` at 0.
- R11: While `sleep` is 1, edges perform no access, stored words are kept, a pending write stays pending and `rdata_oe` is 0. After a sleep spanning at least one rising edge, `rdata_oe` stays 0 until an enabled edge captures a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls the pipeline |
| sel1_n | input | 1 | Select term, active low |
| sel2 | input | 1 | Select term, active high |
| sel3_n | input | 1 | Select term, active low |
| advance | input | 1 | 1 = advance burst, 0 = load new address |
| wr_n | input | 1 | Access type at load: 0 write, 1 read |
| lane_wr_n | input | NB | Per-lane write strobes, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | AW | Word address |
| wdata | input | NB*9 | Write data, 9 bits per lane |
| rdata | output | NB*9 | Read data |
| rdata_oe | output | 1 | Read data is being driven |

## Verification
The hardest state to reach is a write whose data phase is still outstanding when the command stream is interrupted by a stall, a sleep interval or a deselect. The bench sends a write command and then holds the clock enable high or raises sleep for several edges, with junk on the write bus the whole time. It then supplies the real data on the first enabled edge and reads the address back on that same edge. Near-exhaustive burst sweeps start a five-beat burst from every base address in both orders, so that every wrap point of the counter is crossed. On each advance edge, `wr_n` is driven to the opposite of the loaded type.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int LANE_W = 9;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low two address bits of burst beat n starting from base bits b.
  function automatic logic [1:0] beat_low(input logic [1:0] b, input logic [1:0] n,
                                          input burst_order_e ord);
    return (ord == ORD_INTERLEAVE) ? (b ^ n) : (b + n);
  endfunction

endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq import sbs_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic          adv_ok,
  input  logic [AW-1:0] addr,
  input  logic          order_ilv,
  output logic [AW-1:0] beat_addr
);
  localparam int HI_W = AW - 2;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  burst_order_e  ord;

  assign ord    = burst_order_e'(order_ilv);
  assign cnt_nx = cnt_q + 2'd1;

  // Address of the beat captured at this edge.
  always_comb begin
    if (load) beat_addr = addr;
    else      beat_addr = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_nx, ord)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step && load) begin
      base_q <= addr;
      cnt_q  <= '0;
    end else if (step && adv_ok) begin
      cnt_q  <= cnt_nx;
    end
  end

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && adv_ok) |=> (cnt_q == $past(cnt_q) + 2'd1));

  p_load_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load) |=> (cnt_q == 2'd0 && base_q == $past(addr)));

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |-> (beat_addr[AW-1:2] == base_q[HI_W+1:2]));

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl import sbs_pkg::*; #(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          sleep,
  input  logic          sel,
  input  logic          advance,
  input  logic          wr_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic [AW-1:0] addr,
  input  logic          order_ilv,
  output logic          acc_rd,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [NB-1:0] acc_lane_n,
  output logic          commit
);
  logic          step;
  logic          load;
  logic          adv_ok;
  logic          active_q;
  logic          type_wr_q;
  logic          acc_rd_q;
  logic          acc_wr_q;
  logic [AW-1:0] acc_addr_q;
  logic [NB-1:0] acc_lane_q;
  logic [AW-1:0] beat_addr;

  assign step   = !clk_en_n && !sleep;
  assign load   = !advance && sel;
  assign adv_ok = advance && active_q;

  sbs_burst_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .load      (load),
    .adv_ok    (adv_ok),
    .addr      (addr),
    .order_ilv (order_ilv),
    .beat_addr (beat_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      type_wr_q  <= 1'b0;
      acc_rd_q   <= 1'b0;
      acc_wr_q   <= 1'b0;
      acc_addr_q <= '0;
      acc_lane_q <= '1;
    end else if (sleep) begin
      acc_rd_q <= 1'b0;
    end else if (step) begin
      if (!advance) active_q <= sel;
      if (load)     type_wr_q <= !wr_n;
      acc_rd_q   <= (load && wr_n) || (adv_ok && !type_wr_q);
      acc_wr_q   <= (load && !wr_n) || (adv_ok && type_wr_q);
      acc_addr_q <= beat_addr;
      acc_lane_q <= lane_wr_n;
    end
  end

  assign acc_rd     = acc_rd_q;
  assign acc_wr     = acc_wr_q;
  assign acc_addr   = acc_addr_q;
  assign acc_lane_n = acc_lane_q;
  assign commit     = step && acc_wr_q;

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !sleep) |=> $stable({active_q, type_wr_q, acc_rd_q, acc_wr_q, acc_addr_q}));

  p_type_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && advance && active_q) |=> (acc_wr_q == $past(type_wr_q) && active_q));

  p_desel_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !advance && !sel) |=> (!active_q && !acc_rd_q && !acc_wr_q));

  p_idle_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && advance && !active_q) |=> (!acc_rd_q && !acc_wr_q));

  p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd_q && acc_wr_q));

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!acc_rd_q && $stable(acc_wr_q) && $stable(active_q)));

endmodule

// File: rtl/sbs_store.sv
module sbs_store import sbs_pkg::*; #(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic                 clk,
  input  logic                 commit,
  input  logic [AW-1:0]        waddr,
  input  logic [NB-1:0]        lane_off_n,
  input  logic [NB*LANE_W-1:0] wword,
  input  logic [AW-1:0]        raddr,
  output logic [NB*LANE_W-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && !lane_off_n[g]) cells[waddr] <= wword[g*LANE_W +: LANE_W];
    end

    assign rword[g*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram import sbs_pkg::*; #(
  parameter int AW = 6,
  parameter int NB = 2,
  localparam int DW = NB * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          advance,
  input  logic          wr_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic          order_ilv,
  input  logic          out_en_n,
  input  logic          sleep,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  logic          sel;
  logic          acc_rd;
  logic          acc_wr;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] acc_lane_n;
  logic          commit;

  assign sel = !sel1_n && sel2 && !sel3_n;

  sbs_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .sleep      (sleep),
    .sel        (sel),
    .advance    (advance),
    .wr_n       (wr_n),
    .lane_wr_n  (lane_wr_n),
    .addr       (addr),
    .order_ilv  (order_ilv),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_lane_n (acc_lane_n),
    .commit     (commit)
  );

  sbs_store #(.AW(AW), .NB(NB)) u_store (
    .clk        (clk),
    .commit     (commit),
    .waddr      (acc_addr),
    .lane_off_n (acc_lane_n),
    .wword      (wdata),
    .raddr      (acc_addr),
    .rword      (rdata)
  );

  assign rdata_oe = acc_rd && !out_en_n && !sleep;

  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |-> !rdata_oe);

  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sleep && !advance && !sel) |=> !rdata_oe);

  p_commit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!clk_en_n && !sleep && acc_wr));

endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 18;
  localparam int DEPTH = 64;
  localparam int K_LR = 0, K_LW = 1, K_ADV = 2, K_DSL = 3, K_STL = 4;

  logic clk = 0, rst_n = 0;
  logic clk_en_n = 0, sel1_n = 1, sel2 = 0, sel3_n = 1, advance = 0, wr_n = 1;
  logic [NB-1:0] lane_wr_n = '1;
  logic order_ilv = 0, out_en_n = 0, sleep = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  sync_burst_sram #(.AW(AW), .NB(NB)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .advance(advance), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .order_ilv(order_ilv), .out_en_n(out_en_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, salt = 0;
  bit finished = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [2:0] dsel_code = 3'b000;
  // bench-side model of the requirements
  bit m_act = 0, m_wr = 0, m_rd = 0, m_pend = 0;
  int m_base = 0, m_cnt = 0, m_ra = 0, m_pa = 0;
  logic [1:0] m_pbe = 2'b11;

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 1103 + s * 4099 + 777) ^ (a << 11));
  endfunction

  function automatic logic [DW-1:0] junk(input int a, input int s);
    return ~pat(a + 5, s + 99);
  endfunction

  function automatic int beat(input int b, input int n, input logic ilv);
    int lo;
    lo = ilv ? ((b % 4) ^ n) : (((b % 4) + n) % 4);
    return (b & ~3) | lo;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_bus(input string req);
    if (m_rd && !out_en_n) begin
      chk(rdata_oe === 1'b1, req, "drive", 32'(rdata_oe), 1);
      chk(rdata === ref_mem[m_ra], req, "data", 32'(rdata), 32'(ref_mem[m_ra]));
    end else begin
      chk(rdata_oe === 1'b0, req, "drive", 32'(rdata_oe), 0);
    end
  endtask

  task automatic op(input int kind, input int a, input logic [1:0] be, input string req);
    bit hit;
    int ba;
    clk_en_n = (kind == K_STL);
    advance  = (kind == K_ADV);
    {sel1_n, sel2, sel3_n} = (kind == K_DSL) ? dsel_code : 3'b010;
    wr_n = (kind == K_ADV) ? m_wr : (kind != K_LW);   // R5: opposite type on advance
    lane_wr_n = be;
    addr = AW'(a);
    wdata = (m_pend && kind != K_STL) ? pat(m_pa, salt) : junk(a, salt);
    tick();
    if (kind != K_STL) begin
      if (m_pend)
        for (int g = 0; g < NB; g++)
          if (!m_pbe[g]) ref_mem[m_pa][g*9 +: 9] = wdata[g*9 +: 9];
      m_pend = 0;
      hit = 0;
      if (kind == K_LR || kind == K_LW) begin
        m_base = a; m_cnt = 0; m_wr = (kind == K_LW); m_act = 1; hit = 1;
      end else if (kind == K_ADV) begin
        if (m_act) begin m_cnt = (m_cnt + 1) % 4; hit = 1; end
      end else begin
        m_act = 0;
      end
      ba = beat(m_base, m_cnt, order_ilv);
      m_rd = hit && !m_wr;
      m_ra = ba;
      if (hit && m_wr) begin m_pend = 1; m_pa = ba; m_pbe = be; end
    end
    expect_bus(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk(rdata_oe === 1'b0, "R8", "reset drive", 32'(rdata_oe), 0);
    rst_n = 1;
    tick();
    chk(rdata_oe === 1'b0, "R8", "post-reset drive", 32'(rdata_oe), 0);

    // Fill every word with full-lane writes (R3, R6, R8)
    for (int a = 0; a < DEPTH; a++) op(K_LW, a, 2'b00, "R8");
    op(K_DSL, 0, 2'b11, "R2");
    for (int a = 0; a < DEPTH; a++) op(K_LR, a, 2'b11, "R3");

    // Burst writes with rotating lane strobes, both orders (R4, R5, R6)
    salt = 1;
    for (int b = 0; b < DEPTH; b++) begin
      order_ilv = b[2];
      op(K_LW, b, 2'(b), "R6");
      for (int n = 1; n < 4; n++) op(K_ADV, 0, 2'(b + n), "R5");
    end
    op(K_DSL, 0, 2'b11, "R10");

    // Five-beat read bursts from every base, both orders (R4, R5, R7)
    for (int o = 0; o < 2; o++)
      for (int b = 0; b < DEPTH; b++) begin
        order_ilv = o[0];
        op(K_LR, b, 2'b11, "R7");
        for (int n = 1; n < 5; n++) op(K_ADV, 0, 2'b00, "R4");
      end

    // Write then read of the same word with no gap (R7)
    salt = 2;
    for (int a = 0; a < 16; a++) begin
      op(K_LW, a * 3, 2'b00, "R6");
      op(K_LR, a * 3, 2'b11, "R7");
    end

    // Stalls: held read, then pending write across stalls (R1)
    salt = 3;
    op(K_LR, 9, 2'b11, "R1");
    for (int i = 0; i < 3; i++) op(K_STL, 40, 2'b00, "R1");
    op(K_LW, 21, 2'b00, "R1");
    for (int i = 0; i < 3; i++) op(K_STL, 21, 2'b00, "R1");
    op(K_LR, 21, 2'b11, "R1");

    // Every non-selecting code, advance after deselect, stalls (R2, R8, R10)
    for (int c = 0; c < 8; c++) begin
      if (c != 2) begin
        op(K_LR, c + 30, 2'b11, "R2");
        dsel_code = 3'(c);
        op(K_DSL, 11, 2'b11, "R2");
        op(K_STL, 11, 2'b11, "R8");
        op(K_ADV, 0, 2'b00, "R10");
      end
    end
    op(K_LR, 5, 2'b11, "R2");

    // Write with all strobes high writes nothing (R6)
    salt = 4;
    op(K_LW, 17, 2'b11, "R6");
    op(K_LR, 17, 2'b11, "R6");
    op(K_LW, 18, 2'b10, "R6");
    op(K_LR, 18, 2'b11, "R6");

    // Asynchronous output enable (R9)
    op(K_LR, 44, 2'b11, "R9");
    out_en_n = 1; #1;
    chk(rdata_oe === 1'b0, "R9", "oe off", 32'(rdata_oe), 0);
    out_en_n = 0; #1;
    chk(rdata_oe === 1'b1, "R9", "oe on", 32'(rdata_oe), 1);
    chk(rdata === ref_mem[44], "R9", "data", 32'(rdata), 32'(ref_mem[44]));

    // Sleep: held read drops, pending write survives (R11)
    salt = 5;
    op(K_LR, 12, 2'b11, "R11");
    sleep = 1; #1;
    chk(rdata_oe === 1'b0, "R11", "sleep drive", 32'(rdata_oe), 0);
    tick();
    sleep = 0; #1;
    m_rd = 0;
    chk(rdata_oe === 1'b0, "R11", "wake drive", 32'(rdata_oe), 0);
    op(K_LW, 50, 2'b00, "R11");
    sleep = 1;
    for (int i = 0; i < 3; i++) begin
      {sel1_n, sel2, sel3_n} = 3'b010; advance = 0; wr_n = 0; clk_en_n = 0;
      addr = AW'(12); lane_wr_n = 2'b00; wdata = junk(12, i);
      tick();
      chk(rdata_oe === 1'b0, "R11", "asleep drive", 32'(rdata_oe), 0);
    end
    sleep = 0; #1;
    chk(rdata_oe === 1'b0, "R11", "wake drive", 32'(rdata_oe), 0);
    op(K_LR, 50, 2'b11, "R11");
    op(K_LR, 12, 2'b11, "R11");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule